// File: doc/BRIEF.md
# Slot-Timed Power Rail Sequencer

This block switches a bank of power-domain enables on and off at programmed points in time. Three shared sequence timers each watch a trigger, which is one of two hardware enable pins or a software bit held in the timer's configuration. When the trigger changes level, the timer issues eight numbered slot events, 0 through 7. The events are spaced by a period that doubles with each step of a 3-bit code, starting from a base of 40 µs. A prescaler turns the system clock into a 1 µs tick, and the slot periods are counted in these ticks.

Each output channel (a regulator, a general-purpose pin or a clock enable) has its own configuration word. The word selects one of the three timers or a direct software bit. It also sets the slot at which the channel powers up on a rising sequence and the slot at which it acts on a falling sequence. A last field says what the channel does at that falling slot: switch off (sleep), drop into low-power mode (regulators only), or nothing. Configuration is loaded through a plain parallel write port.

Top module: `rail_seq_ctrl`

## Requirements
- R1: While reset is asserted, and after its release with no writes made, every rail_en, rail_lp, seq_busy and seq_done bit is 0.
- R2: Timer configuration word, written at address t (0..2): bits [1:0] select the trigger (0 = hw_en0, 1 = hw_en1, 2 = the software trigger bit, 3 = held low), bits [4:2] hold the period code and bit 5 is the software trigger. Every change of level of the selected trigger starts a sequence of slot events 0..7 in that direction.
- R3: Slot k of a sequence comes k × (40 << code) µs after slot 0, where 1 µs is CLK_PER_US clock cycles. The spacing is exact to within one µs tick.
- R4: Channel word, written at address 16 + i: bits [1:0] select the source (0..2 = timer, 3 = software), [4:2] the power-up slot, [7:5] the power-down slot, [9:8] the falling-sequence mode (1 = sleep, 2 = low-power, 0 or 3 = none), and [10] the software enable. On a rising sequence of its timer, a channel sets rail_en = 1 and rail_lp = 0 one cycle after the event for its power-up slot.
- R5: A channel that follows a timer changes rail_en or rail_lp only in the cycle after that timer issues the channel's own up or down slot.
- R6: In sleep mode, the falling-sequence event for the down slot clears both rail_en and rail_lp.
- R7: In low-power mode, a regulator channel (REG_MASK bit set) that is enabled sets rail_lp and keeps rail_en high. A non-regulator channel, or one that is off, does not change. rail_lp is only ever high together with rail_en.
- R8: With no falling-sequence mode set, a channel keeps its state through a falling sequence.
- R9: A channel in software mode drives rail_en from its software bit in the cycle after the configuration register holds that bit, with rail_lp = 0 and no slot delay.
- R10: A trigger change during a sequence restarts the timer at slot 0 in the new direction. Slot timing and the done pulse then follow from the restart point.
- R11: seq_busy is high from the start of a sequence until slot 7 is issued. seq_done is a one-cycle pulse in the slot-7 cycle, and seq_busy is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_en0 | input | 1 | Hardware trigger pin 0 |
| hw_en1 | input | 1 | Hardware trigger pin 1 |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | ADDR_W | Configuration register address |
| wr_data | input | DATA_W | Configuration write data |
| rail_en | output | NUM_SLAVES | Per-channel enable |
| rail_lp | output | NUM_SLAVES | Per-channel low-power request |
| seq_busy | output | 3 | Timer sequence in progress |
| seq_done | output | 3 | Timer finished slot 7 (one cycle) |

## Verification
The case that is hardest to reach from the ports is a trigger reversal in the middle of a sequence. The bench raises hw_en1 and waits until the timer is between two of its later slots. It then drops the pin and checks that the down slot and the done pulse are timed from the reversal and not from the first start. A second hard case is a falling sequence in low-power mode that leaves the rail enabled. The regulator is powered up first and then brought down, so its rail_lp rises while rail_en stays high. A following rising sequence must then clear rail_lp alone.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;
   localparam int NUM_TMR = 3;
   localparam int SLOT_W  = 3;
   localparam int CODE_W  = 3;

   localparam logic [1:0] TRIG_EN0 = 2'd0;
   localparam logic [1:0] TRIG_EN1 = 2'd1;
   localparam logic [1:0] TRIG_SW  = 2'd2;
   localparam logic [1:0] SRC_SW   = 2'd3;
   localparam logic [1:0] MODE_SLEEP  = 2'd1;
   localparam logic [1:0] MODE_LOWPWR = 2'd2;

   typedef struct packed {
      logic              sw_trig;
      logic [CODE_W-1:0] code;
      logic [1:0]        src;
   } tmr_cfg_t;

   typedef struct packed {
      logic              sw_en;
      logic [1:0]        mode;
      logic [SLOT_W-1:0] dn_slot;
      logic [SLOT_W-1:0] up_slot;
      logic [1:0]        src;
   } slv_cfg_t;

   typedef struct packed {
      logic              valid;
      logic              dir;
      logic [SLOT_W-1:0] slot;
   } slot_ev_t;
endpackage

// File: rtl/rs_tick_gen.sv
module rs_tick_gen #(
   parameter int CLK_PER_US = 50
)(
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   if (CLK_PER_US == 1) begin : g_passthru
      assign tick = 1'b1;
   end else begin : g_div
      localparam int W = $clog2(CLK_PER_US);
      logic [W-1:0] cnt_q;
      assign tick = (cnt_q == W'(CLK_PER_US - 1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    cnt_q <= '0;
         else if (tick) cnt_q <= '0;
         else           cnt_q <= cnt_q + W'(1);
      end
   end
endmodule

// File: rtl/rs_slot_timer.sv
module rs_slot_timer import rail_seq_pkg::*; #(
   parameter int BASE_US = 40
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              trig,
   input  logic [CODE_W-1:0] code,
   output slot_ev_t          ev,
   output logic              busy,
   output logic              done
);
   localparam int MAX_US = BASE_US << ((1 << CODE_W) - 1);
   localparam int CNT_W  = $clog2(MAX_US + 1);

   logic              trig_q;
   logic [SLOT_W-1:0] slot_q;
   logic [CNT_W-1:0]  us_q;
   logic [CNT_W-1:0]  period;

   assign period = CNT_W'(BASE_US) << code;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig_q <= 1'b0;
         slot_q <= '0;
         us_q   <= '0;
         ev     <= '0;
         busy   <= 1'b0;
         done   <= 1'b0;
      end else begin
         ev.valid <= 1'b0;
         done     <= 1'b0;
         if (trig != trig_q) begin
            trig_q <= trig;
            ev     <= '{valid: 1'b1, dir: trig, slot: '0};
            slot_q <= '0;
            us_q   <= '0;
            busy   <= 1'b1;
         end else if (busy && tick) begin
            if (us_q == period - CNT_W'(1)) begin
               us_q   <= '0;
               slot_q <= slot_q + SLOT_W'(1);
               ev     <= '{valid: 1'b1, dir: trig_q, slot: slot_q + SLOT_W'(1)};
               if (slot_q == SLOT_W'((1 << SLOT_W) - 2)) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end
            end else begin
               us_q <= us_q + CNT_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/rs_slave.sv
module rs_slave import rail_seq_pkg::*; #(
   parameter bit IS_REG = 1'b1
)(
   input  logic     clk,
   input  logic     rst_n,
   input  slv_cfg_t cfg,
   input  slot_ev_t ev [NUM_TMR],
   output logic     en,
   output logic     lp
);
   slot_ev_t sel;
   logic     hit_up, hit_dn, lp_on_dn;

   always_comb begin
      case (cfg.src)
         2'd0:    sel = ev[0];
         2'd1:    sel = ev[1];
         2'd2:    sel = ev[2];
         default: sel = '0;
      endcase
   end

   assign hit_up = sel.valid &&  sel.dir && (sel.slot == cfg.up_slot);
   assign hit_dn = sel.valid && !sel.dir && (sel.slot == cfg.dn_slot);

   if (IS_REG) begin : g_reg
      assign lp_on_dn = en;
   end else begin : g_plain
      assign lp_on_dn = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en <= 1'b0;
         lp <= 1'b0;
      end else if (cfg.src == SRC_SW) begin
         en <= cfg.sw_en;
         lp <= 1'b0;
      end else if (hit_up) begin
         en <= 1'b1;
         lp <= 1'b0;
      end else if (hit_dn) begin
         case (cfg.mode)
            MODE_SLEEP: begin
               en <= 1'b0;
               lp <= 1'b0;
            end
            MODE_LOWPWR: lp <= lp_on_dn;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/rail_seq_ctrl.sv
module rail_seq_ctrl import rail_seq_pkg::*; #(
   parameter int          NUM_SLAVES = 6,
   parameter int          CLK_PER_US = 50,
   parameter int          BASE_US    = 40,
   parameter logic [15:0] REG_MASK   = 16'h000F,
   parameter int          ADDR_W     = 5,
   parameter int          DATA_W     = 16
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  hw_en0,
   input  logic                  hw_en1,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     wr_addr,
   input  logic [DATA_W-1:0]     wr_data,
   output logic [NUM_SLAVES-1:0] rail_en,
   output logic [NUM_SLAVES-1:0] rail_lp,
   output logic [NUM_TMR-1:0]    seq_busy,
   output logic [NUM_TMR-1:0]    seq_done
);
   localparam int SLV_BASE = 1 << (ADDR_W - 1);
   localparam int TCFG_W   = $bits(tmr_cfg_t);
   localparam int SCFG_W   = $bits(slv_cfg_t);

   if (NUM_SLAVES < 1 || NUM_SLAVES > SLV_BASE || NUM_SLAVES > 16) begin : g_bad_slaves
      $error("NUM_SLAVES out of range for the address map");
   end
   if (DATA_W < SCFG_W) begin : g_bad_data
      $error("DATA_W too narrow for a channel word");
   end
   if (CLK_PER_US < 1 || BASE_US < 1) begin : g_bad_time
      $error("CLK_PER_US and BASE_US must be positive");
   end

   logic     tick;
   tmr_cfg_t tcfg_q [NUM_TMR];
   slv_cfg_t scfg_q [NUM_SLAVES];
   slot_ev_t tev    [NUM_TMR];
   logic [NUM_TMR-1:0] trig;

   rs_tick_gen #(.CLK_PER_US(CLK_PER_US)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick)
   );

   for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            tcfg_q[t] <= '0;
         else if (wr_en && wr_addr == ADDR_W'(t))
            tcfg_q[t] <= tmr_cfg_t'(wr_data[TCFG_W-1:0]);
      end

      always_comb begin
         case (tcfg_q[t].src)
            TRIG_EN0: trig[t] = hw_en0;
            TRIG_EN1: trig[t] = hw_en1;
            TRIG_SW:  trig[t] = tcfg_q[t].sw_trig;
            default:  trig[t] = 1'b0;
         endcase
      end

      rs_slot_timer #(.BASE_US(BASE_US)) u_timer (
         .clk(clk), .rst_n(rst_n), .tick(tick), .trig(trig[t]),
         .code(tcfg_q[t].code), .ev(tev[t]),
         .busy(seq_busy[t]), .done(seq_done[t])
      );
   end

   for (genvar s = 0; s < NUM_SLAVES; s++) begin : g_slv
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            scfg_q[s] <= '0;
         else if (wr_en && wr_addr == ADDR_W'(SLV_BASE + s))
            scfg_q[s] <= slv_cfg_t'(wr_data[SCFG_W-1:0]);
      end

      rs_slave #(.IS_REG(REG_MASK[s])) u_slave (
         .clk(clk), .rst_n(rst_n), .cfg(scfg_q[s]), .ev(tev),
         .en(rail_en[s]), .lp(rail_lp[s])
      );
   end
endmodule

// File: rtl/rail_seq_chk.sv
module rail_seq_chk import rail_seq_pkg::*; #(
   parameter int          NUM_SLAVES = 6,
   parameter logic [15:0] REG_MASK   = 16'h000F
)(
   input logic                  clk,
   input logic                  rst_n,
   input logic [NUM_SLAVES-1:0] rail_en,
   input logic [NUM_SLAVES-1:0] rail_lp,
   input logic [NUM_TMR-1:0]    seq_busy,
   input logic [NUM_TMR-1:0]    seq_done,
   input slv_cfg_t              scfg [NUM_SLAVES],
   input slot_ev_t              tev  [NUM_TMR]
);
   for (genvar t = 0; t < NUM_TMR; t++) begin : g_t
      assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
         seq_done[t] |=> !seq_done[t]);
      assert_done_not_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
         seq_done[t] |-> !seq_busy[t]);
      assert_busy_ends_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(seq_busy[t]) |-> seq_done[t]);
   end

   for (genvar s = 0; s < NUM_SLAVES; s++) begin : g_s
      logic sel_valid;
      always_comb begin
         case (scfg[s].src)
            2'd0:    sel_valid = tev[0].valid;
            2'd1:    sel_valid = tev[1].valid;
            2'd2:    sel_valid = tev[2].valid;
            default: sel_valid = 1'b0;
         endcase
      end

      assert_quiet_between_slots_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (scfg[s].src != SRC_SW && !sel_valid) |=> ($stable(rail_en[s]) && $stable(rail_lp[s])));
      assert_sw_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (scfg[s].src == SRC_SW) |=> (rail_en[s] == $past(scfg[s].sw_en) && !rail_lp[s]));
      assert_lp_with_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
         rail_lp[s] |-> rail_en[s]);
      assert_lp_reg_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
         !REG_MASK[s] |-> !rail_lp[s]);
   end
endmodule

bind rail_seq_ctrl rail_seq_chk #(.NUM_SLAVES(NUM_SLAVES), .REG_MASK(REG_MASK)) u_chk (
   .clk(clk), .rst_n(rst_n), .rail_en(rail_en), .rail_lp(rail_lp),
   .seq_busy(seq_busy), .seq_done(seq_done), .scfg(scfg_q), .tev(tev)
);

// File: tb/rail_seq_ctrl_tb.sv
module rail_seq_ctrl_tb;
   localparam int CPU  = 2;
   localparam int BASE = 40;
   localparam int NS   = 6;

   logic clk = 1'b0;
   logic rst_n, hw_en0, hw_en1, wr_en;
   logic [4:0]    wr_addr;
   logic [15:0]   wr_data;
   logic [NS-1:0] rail_en, rail_lp;
   logic [2:0]    seq_busy, seq_done;

   int cyc = 0;
   int checks = 0;
   int fails = 0;
   bit mon_on = 1'b0;
   bit finished = 1'b0;
   logic [NS-1:0] prev_en, prev_lp;

   typedef struct {
      int    slv;
      int    kind;
      bit    val;
      int    lo;
      int    hi;
      string req;
   } exp_t;
   exp_t sb[$];

   rail_seq_ctrl #(.NUM_SLAVES(NS), .CLK_PER_US(CPU), .BASE_US(BASE)) u_dut (
      .clk(clk), .rst_n(rst_n), .hw_en0(hw_en0), .hw_en1(hw_en1),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rail_en(rail_en), .rail_lp(rail_lp), .seq_busy(seq_busy), .seq_done(seq_done)
   );

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: %s act=%0d exp=%0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   function automatic int slot_cyc(int slot, int code);
      return slot * (BASE << code) * CPU;
   endfunction

   // expected output change, timed from the negedge at which the stimulus was driven
   task automatic expect_ev(int slv, int kind, bit val, int base, int ideal, string req);
      exp_t e;
      e.slv = slv; e.kind = kind; e.val = val;
      e.lo = base + 2 + ideal - CPU;
      e.hi = base + 3 + ideal;
      e.req = req;
      sb.push_back(e);
   endtask

   task automatic match(int slv, int kind, bit val);
      int idx = -1;
      for (int k = 0; k < sb.size(); k++)
         if (idx < 0 && sb[k].slv == slv && sb[k].kind == kind) idx = k;
      if (idx < 0) begin
         check(1'b0, "R5", $sformatf("unexpected change ch%0d kind%0d", slv, kind), int'(val), int'(!val));
      end else begin
         check(sb[idx].val == val, sb[idx].req, $sformatf("value ch%0d kind%0d", slv, kind), int'(val), int'(sb[idx].val));
         check(cyc >= sb[idx].lo && cyc <= sb[idx].hi, sb[idx].req,
               $sformatf("time ch%0d kind%0d", slv, kind), cyc, sb[idx].lo);
         sb.delete(idx);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (mon_on) begin
         for (int i = 0; i < NS; i++) begin
            if (rail_en[i] !== prev_en[i]) match(i, 0, rail_en[i]);
            if (rail_lp[i] !== prev_lp[i]) match(i, 1, rail_lp[i]);
         end
         prev_en <= rail_en;
         prev_lp <= rail_lp;
      end
   end

   task automatic wr(int addr, int data);
      wr_en = 1'b1; wr_addr = 5'(addr); wr_data = 16'(data);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   function automatic int scw(int src, int up, int dn, int mode, int sw);
      return (sw << 10) | (mode << 8) | (dn << 5) | (up << 2) | src;
   endfunction

   function automatic int tcw(int src, int code, int sw);
      return (sw << 5) | (code << 2) | src;
   endfunction

   task automatic wait_done(int t, int base, int code, string req);
      bit found = 1'b0;
      int ideal = slot_cyc(7, code);
      for (int n = 0; n < 20000 && !found; n++) begin
         @(negedge clk);
         if (seq_done[t]) found = 1'b1;
      end
      check(found, req, $sformatf("done pulse timer%0d", t), int'(found), 1);
      check(!seq_busy[t], "R11", "busy low with done", int'(seq_busy[t]), 0);
      check(cyc >= base + 1 + ideal - CPU && cyc <= base + 2 + ideal, req,
            $sformatf("done time timer%0d", t), cyc, base + 1 + ideal);
      @(negedge clk);
      check(!seq_done[t], "R11", "done lasts one cycle", int'(seq_done[t]), 0);
   endtask

   initial begin
      #(20 * 150000);
      $display("FAIL watchdog: run hung act=%0d exp=%0d", cyc, 0);
      checks++;
      fails++;
      summary();
   end

   initial begin
      int c0;
      rst_n = 1'b0; hw_en0 = 1'b0; hw_en1 = 1'b0;
      wr_en = 1'b0; wr_addr = '0; wr_data = '0;
      repeat (3) @(negedge clk);
      check(rail_en == '0, "R1", "rail_en in reset", int'(rail_en), 0);
      check(rail_lp == '0, "R1", "rail_lp in reset", int'(rail_lp), 0);
      check(seq_busy == '0 && seq_done == '0, "R1", "timer flags in reset", int'({seq_busy, seq_done}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      prev_en = rail_en; prev_lp = rail_lp;
      mon_on = 1'b1;

      wr(0, tcw(0, 0, 0));
      wr(1, tcw(1, 1, 0));
      wr(2, tcw(2, 0, 0));
      wr(16, scw(0, 1, 6, 1, 0));
      wr(17, scw(0, 4, 2, 2, 0));
      wr(18, scw(1, 0, 3, 1, 0));
      wr(19, scw(2, 7, 0, 0, 0));
      wr(20, scw(0, 3, 3, 2, 0));
      wr(21, scw(3, 0, 0, 0, 0));
      repeat (4) @(negedge clk);
      check(rail_en == '0 && seq_busy == '0, "R1", "idle after config", int'({rail_en, 3'(seq_busy)}), 0);

      // R2 R3 R4: rising sequence on hw_en0, code 0
      c0 = cyc;
      expect_ev(0, 0, 1'b1, c0, slot_cyc(1, 0), "R4");
      expect_ev(4, 0, 1'b1, c0, slot_cyc(3, 0), "R3");
      expect_ev(1, 0, 1'b1, c0, slot_cyc(4, 0), "R4");
      hw_en0 = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check(seq_busy[0], "R11", "busy during sequence", int'(seq_busy[0]), 1);
      wait_done(0, c0, 0, "R2");

      // R6 R7: falling sequence
      repeat (5) @(negedge clk);
      c0 = cyc;
      expect_ev(1, 1, 1'b1, c0, slot_cyc(2, 0), "R7");
      expect_ev(0, 0, 1'b0, c0, slot_cyc(6, 0), "R6");
      hw_en0 = 1'b0;
      wait_done(0, c0, 0, "R6");
      check(rail_en[4] && !rail_lp[4], "R7", "non-regulator keeps state", int'({rail_en[4], rail_lp[4]}), 2);
      check(rail_en[1] && rail_lp[1], "R7", "regulator in low power", int'({rail_en[1], rail_lp[1]}), 3);

      // R4: rising again clears low power
      repeat (5) @(negedge clk);
      c0 = cyc;
      expect_ev(0, 0, 1'b1, c0, slot_cyc(1, 0), "R4");
      expect_ev(1, 1, 1'b0, c0, slot_cyc(4, 0), "R4");
      hw_en0 = 1'b1;
      wait_done(0, c0, 0, "R4");

      // R10: reversal mid-sequence on hw_en1, code 1
      repeat (5) @(negedge clk);
      c0 = cyc;
      expect_ev(2, 0, 1'b1, c0, 0, "R2");
      hw_en1 = 1'b1;
      while (cyc < c0 + 2 + slot_cyc(2, 1) + slot_cyc(1, 1) / 2) @(negedge clk);
      check(seq_busy[1], "R10", "busy before reversal", int'(seq_busy[1]), 1);
      c0 = cyc;
      expect_ev(2, 0, 1'b0, c0, slot_cyc(3, 1), "R10");
      hw_en1 = 1'b0;
      wait_done(1, c0, 1, "R10");

      // R2 R8: software trigger on timer 2
      repeat (5) @(negedge clk);
      c0 = cyc;
      expect_ev(3, 0, 1'b1, c0 + 1, slot_cyc(7, 0), "R2");
      wr(2, tcw(2, 0, 1));
      wait_done(2, c0 + 1, 0, "R2");
      repeat (3) @(negedge clk);
      c0 = cyc;
      wr(2, tcw(2, 0, 0));
      wait_done(2, c0 + 1, 0, "R8");
      repeat (3) @(negedge clk);
      check(rail_en[3] && !rail_lp[3], "R8", "no mode keeps rail on", int'({rail_en[3], rail_lp[3]}), 2);

      // R9: direct software channel
      c0 = cyc;
      expect_ev(5, 0, 1'b1, c0, 0, "R9");
      wr(21, scw(3, 0, 0, 0, 1));
      @(negedge clk);
      check(rail_en[5] && !rail_lp[5], "R9", "software enable on", int'({rail_en[5], rail_lp[5]}), 2);
      c0 = cyc;
      expect_ev(5, 0, 1'b0, c0, 0, "R9");
      wr(21, scw(3, 0, 0, 0, 0));
      repeat (4) @(negedge clk);
      check(!rail_en[5], "R9", "software enable off", int'(rail_en[5]), 0);

      repeat (10) @(negedge clk);
      mon_on = 1'b0;
      foreach (sb[k])
         check(1'b0, sb[k].req, $sformatf("missing change ch%0d kind%0d", sb[k].slv, sb[k].kind), 0, int'(sb[k].val));
      summary();
   end
endmodule